// File: doc/BRIEF.md
# Supply-Modulated Pulse-Width Command Link

This block lets a test station talk to a two-wire sensor using only the supply line and the sensor's output line. The supply level has already been sliced to one digital signal that says whether it is above or below the mid threshold. Both the bit clock and the data ride on the duty cycle of that signal. A period whose high phase is longer than half the measured period carries a one. A period with a short high phase carries a zero. Every period also shifts one reply bit onto the output line. A long low phase closes a word, and a long high phase closes the whole session.

Before any of this the part has to enter test mode, and there are two ways to do it. A blank (never-fused) device enters when its output line is pulled low from outside for long enough, shortly after a power-on pulse. Any device enters when the supply echoes the output in inverted form for several output periods, following each output edge within a small number of clocks. Received words are presented with a one-cycle strobe. Only the most recent fourteen bits of a word count: thirteen data bits, then a stop bit.

Top module: `vsl_link`

## Requirements
- R1: After reset, `test_mode` and `rx_valid` are 0 and `out_drive` is 1 (line released).
- R2: With `blank_dev`=1, holding `out_sense` low for LOW_HOLD consecutive clocks, starting within ENTRY_WIN clocks after `por_pulse` (or reset), sets `test_mode`. With `blank_dev`=0 the same stimulus leaves `test_mode` at 0.
- R3: Outside test mode, FOLLOW_N consecutive rising edges of `out_sense` set `test_mode`, provided that throughout those periods `supply_hi` equals the inverse of `out_sense` except for lags of at most LAG_MAX clocks after each edge.
- R4: If `supply_hi` fails to be the inverse of `out_sense` for more than LAG_MAX consecutive clocks, the echo count restarts, and FOLLOW_N further good rising edges are needed.
- R5: In test mode, each rising edge of `supply_hi` after the first one of a word completes one bit. The bit is 1 when the high time of the completed period, doubled, exceeds the period length, and 0 otherwise.
- R6: Bits are received LSB first. At word end the last fourteen received bits form the frame: the first thirteen of them are `rx_word` bits 0..12 in arrival order, and the most recent bit is the stop bit, which must be 1. Earlier surplus bits are discarded.
- R7: A word with fewer than fourteen bits, or with a stop bit of 0, produces no `rx_valid`.
- R8: A word ends when `supply_hi` has been low for WORD_GAP consecutive clocks. An accepted word raises `rx_valid` for exactly one clock.
- R9: In test mode the n-th rising edge of `supply_hi` in a word (n from 0) drives `out_drive` to `tx_word[n]` for n<13 and to 1 after that. Outside test mode `out_drive` is 1.
- R10: `supply_hi` held high for SESSION_END consecutive clocks in test mode clears `test_mode`. After that, supply pulses produce no words until test mode is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_pulse | input | 1 | Power-on pulse; clears the link and opens the held-low entry window |
| blank_dev | input | 1 | 1 when the device has never been programmed |
| supply_hi | input | 1 | Supply above the mid threshold |
| out_sense | input | 1 | Sensed level of the output line |
| tx_word | input | 13 | Reply word shifted out LSB first |
| test_mode | output | 1 | Link session active |
| rx_word | output | 13 | Last accepted data word |
| rx_valid | output | 1 | One-clock strobe for `rx_word` |
| out_drive | output | 1 | Requested output line level (1 = released) |

## Verification
The hardest state to reach is the echo entry with an aborted attempt in the middle. The bench plays an output waveform on `out_sense` and answers it on `supply_hi` with a programmable lag. One period uses a lag beyond LAG_MAX, which must reset the count. The bench then checks that exactly FOLLOW_N further good edges are needed. Words are sent at three different bit periods, with surplus leading bits, with too few bits and with a bad stop bit. This covers decoding relative to the measured period and the framing rule.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
   // bit event passed from the timing stage to the framer
   typedef struct packed {
      logic valid;
      logic value;
   } vsl_bit_t;
endpackage

// File: rtl/vsl_sync.sv
module vsl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_ff
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= {STAGES{RST_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/vsl_bit_timer.sv
module vsl_bit_timer
   import vsl_pkg::*;
#(
   parameter int WORD_GAP    = 352,
   parameter int SESSION_END = 1760
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     test_en,
   input  logic     sup,
   output vsl_bit_t bit_o,
   output logic     rise_v,
   output logic     word_end,
   output logic     sess_end
);
   localparam int CW = $clog2(SESSION_END + 1) + 1;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic          sup_q, have_rise;
   logic [CW-1:0] run, run_nx, pcnt, hcnt;
   logic          rise, chg, gap_hit, end_hit;

   assign rise    = sup & ~sup_q;
   assign chg     = sup ^ sup_q;
   assign run_nx  = chg ? CW'(1) : ((run == CW'(SESSION_END)) ? run : run + 1'b1);
   assign gap_hit = test_en && !sup && (run_nx == CW'(WORD_GAP)) && (run != CW'(WORD_GAP));
   assign end_hit = test_en && sup && (run_nx == CW'(SESSION_END)) && (run != CW'(SESSION_END));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_q <= 1'b0; run <= '0; pcnt <= '0; hcnt <= '0; have_rise <= 1'b0;
         bit_o <= '0; rise_v <= 1'b0; word_end <= 1'b0; sess_end <= 1'b0;
      end else if (clr) begin
         sup_q <= sup; run <= '0; pcnt <= '0; hcnt <= '0; have_rise <= 1'b0;
         bit_o <= '0; rise_v <= 1'b0; word_end <= 1'b0; sess_end <= 1'b0;
      end else begin
         sup_q    <= sup;
         run      <= run_nx;
         pcnt     <= rise ? CW'(1) : ((pcnt == CMAX) ? pcnt : pcnt + 1'b1);
         if (rise)                    hcnt <= CW'(1);
         else if (sup && hcnt != CMAX) hcnt <= hcnt + 1'b1;
         bit_o.valid <= test_en && rise && have_rise;
         if (rise) bit_o.value <= ({1'b0, hcnt} << 1) > {1'b0, pcnt};
         rise_v   <= test_en && rise;
         word_end <= gap_hit;
         sess_end <= end_hit;
         if (!test_en || gap_hit) have_rise <= 1'b0;
         else if (rise)           have_rise <= 1'b1;
      end
   end

   // R5: bit, word-end and session-end events never coincide
   p_events_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bit_o.valid, word_end, sess_end}));
   // R8: a word end only follows a low supply
   p_word_end_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |-> !$past(sup));
endmodule

// File: rtl/vsl_entry.sv
module vsl_entry #(
   parameter int LOW_HOLD  = 1760,
   parameter int ENTRY_WIN = 3520,
   parameter int LAG_MAX   = 40,
   parameter int FOLLOW_N  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic por,
   input  logic blank,
   input  logic sup,
   input  logic osense,
   input  logic sess_end,
   output logic test_mode
);
   localparam int WW = $clog2(ENTRY_WIN + 1);
   localparam int LW = $clog2(LOW_HOLD + 1);
   localparam int MW = $clog2(LAG_MAX + 2);
   localparam int FW = $clog2(FOLLOW_N + 1);

   logic [WW-1:0] win_cnt;
   logic [LW-1:0] low_cnt, low_nx;
   logic [MW-1:0] mis_cnt;
   logic [FW-1:0] fcnt;
   logic          osq, in_win, orise, mism, abort, enter_hold, enter_echo;

   assign in_win     = win_cnt != WW'(ENTRY_WIN);
   assign low_nx     = (!test_mode && blank && !osense && (in_win || low_cnt != '0))
                       ? ((low_cnt == LW'(LOW_HOLD)) ? low_cnt : low_cnt + 1'b1) : '0;
   assign enter_hold = low_nx == LW'(LOW_HOLD);
   assign orise      = osense & ~osq;
   assign mism       = sup == osense;
   assign abort      = mism && (mis_cnt >= MW'(LAG_MAX));
   assign enter_echo = !test_mode && !abort && orise && (fcnt == FW'(FOLLOW_N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0; low_cnt <= '0; mis_cnt <= '0; fcnt <= '0; osq <= 1'b1; test_mode <= 1'b0;
      end else if (por) begin
         win_cnt <= '0; low_cnt <= '0; mis_cnt <= '0; fcnt <= '0; osq <= osense; test_mode <= 1'b0;
      end else begin
         osq     <= osense;
         if (in_win) win_cnt <= win_cnt + 1'b1;
         low_cnt <= low_nx;
         mis_cnt <= !mism ? '0 : ((mis_cnt == MW'(LAG_MAX + 1)) ? mis_cnt : mis_cnt + 1'b1);
         if (test_mode || abort) fcnt <= '0;
         else if (orise)         fcnt <= fcnt + 1'b1;
         if (sess_end)                       test_mode <= 1'b0;
         else if (enter_hold || enter_echo)  test_mode <= 1'b1;
      end
   end

   // R4: a broken echo restarts the count
   p_abort_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !por) |=> (fcnt == '0));
   // R10: the session persists until a long high or a power-on pulse
   p_session_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !sess_end && !por) |=> test_mode);
endmodule

// File: rtl/vsl_framer.sv
module vsl_framer
   import vsl_pkg::*;
#(
   parameter int   WORD_W   = 13,
   parameter logic STOP_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              test_en,
   input  vsl_bit_t          bit_i,
   input  logic              rise_v,
   input  logic              word_end,
   input  logic [WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              q_bit
);
   localparam int FRAME_W = WORD_W + 1;
   localparam int CNW     = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sr;
   logic [CNW-1:0]     nbits;
   logic [WORD_W-1:0]  rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0; nbits <= '0; rsh <= '0; q_bit <= 1'b1; rx_word <= '0; rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (clr || !test_en) begin
            sr <= '0; nbits <= '0; rsh <= tx_word; q_bit <= 1'b1;
         end else if (word_end) begin
            nbits <= '0; rsh <= tx_word; q_bit <= 1'b1;
            if (nbits == CNW'(FRAME_W) && sr[FRAME_W-1] == STOP_VAL) begin
               rx_valid <= 1'b1;
               rx_word  <= sr[WORD_W-1:0];
            end
         end else begin
            if (bit_i.valid) begin
               sr <= {bit_i.value, sr[FRAME_W-1:1]};
               if (nbits != CNW'(FRAME_W)) nbits <= nbits + 1'b1;
            end
            if (rise_v) begin
               q_bit <= rsh[0];
               rsh   <= {1'b1, rsh[WORD_W-1:1]};
            end
         end
      end
   end

   // R8: the strobe lasts one clock
   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R6: words are only accepted inside a session
   p_valid_in_session_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(test_en));
endmodule

// File: rtl/vsl_link.sv
module vsl_link
   import vsl_pkg::*;
#(
   parameter int   WORD_W      = 13,
   parameter logic STOP_VAL    = 1'b1,
   parameter int   SYNC_STAGES = 2,
   parameter int   WORD_GAP    = 352,
   parameter int   SESSION_END = 1760,
   parameter int   LOW_HOLD    = 1760,
   parameter int   ENTRY_WIN   = 3520,
   parameter int   LAG_MAX     = 40,
   parameter int   FOLLOW_N    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_pulse,
   input  logic              blank_dev,
   input  logic              supply_hi,
   input  logic              out_sense,
   input  logic [WORD_W-1:0] tx_word,
   output logic              test_mode,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              out_drive
);
   generate
      if (SESSION_END <= WORD_GAP) begin : g_bad_gap
         $error("SESSION_END must exceed WORD_GAP");
      end
      if (WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..3");
      end
      if (FOLLOW_N < 1 || LOW_HOLD < 1) begin : g_bad_count
         $error("FOLLOW_N and LOW_HOLD must be positive");
      end
   endgenerate

   logic     sup_s, osn_s, rise_v, word_end, sess_end, q_bit;
   vsl_bit_t bit_ev;

   vsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(supply_hi), .q(sup_s));
   vsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_out (
      .clk(clk), .rst_n(rst_n), .d(out_sense), .q(osn_s));

   vsl_entry #(.LOW_HOLD(LOW_HOLD), .ENTRY_WIN(ENTRY_WIN), .LAG_MAX(LAG_MAX),
               .FOLLOW_N(FOLLOW_N)) u_entry (
      .clk(clk), .rst_n(rst_n), .por(por_pulse), .blank(blank_dev), .sup(sup_s),
      .osense(osn_s), .sess_end(sess_end), .test_mode(test_mode));

   vsl_bit_timer #(.WORD_GAP(WORD_GAP), .SESSION_END(SESSION_END)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(por_pulse), .test_en(test_mode), .sup(sup_s),
      .bit_o(bit_ev), .rise_v(rise_v), .word_end(word_end), .sess_end(sess_end));

   vsl_framer #(.WORD_W(WORD_W), .STOP_VAL(STOP_VAL)) u_framer (
      .clk(clk), .rst_n(rst_n), .clr(por_pulse), .test_en(test_mode), .bit_i(bit_ev),
      .rise_v(rise_v), .word_end(word_end), .tx_word(tx_word), .rx_word(rx_word),
      .rx_valid(rx_valid), .q_bit(q_bit));

   assign out_drive = test_mode ? q_bit : 1'b1;

   // R9: the line is released outside a session
   p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> out_drive);
endmodule

// File: tb/vsl_link_tb.sv
module vsl_link_tb;
   logic        clk = 1'b0, rst_n = 1'b0, por_pulse = 1'b0, blank_dev = 1'b0;
   logic        supply_hi = 1'b0, out_sense = 1'b1;
   logic [12:0] tx_word;
   logic        test_mode, rx_valid, out_drive;
   logic [12:0] rx_word;

   localparam logic [12:0] TXW = 13'h0B5A;
   int nchk = 0, nfail = 0;
   logic [12:0] exp_q[$];
   logic prev_valid = 1'b0;

   always #2 clk = ~clk;

   vsl_link u_dut (.clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .blank_dev(blank_dev),
      .supply_hi(supply_hi), .out_sense(out_sense), .tx_word(tx_word), .test_mode(test_mode),
      .rx_word(rx_word), .rx_valid(rx_valid), .out_drive(out_drive));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every strobe
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(prev_valid && rx_valid), "R8 strobe width", 2, 1);
         if (rx_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word", int'(rx_word), -1);
            else begin
               logic [12:0] e;
               e = exp_q.pop_front();
               chk(rx_word == e, "R5 R6 word", int'(rx_word), int'(e));
            end
         end
         prev_valid <= rx_valid;
      end
   end

   task automatic pulse_por();
      @(negedge clk); por_pulse = 1'b1;
      @(negedge clk); por_pulse = 1'b0;
   endtask

   // driver: sends n bits (bits[0] first) at period per, then the closing pulse
   task automatic send_word(input logic [19:0] bits, input int n, input int per,
                            input bit expect_rx, input bit chk_reply);
      if (expect_rx && n >= 14 && bits[n-1] == 1'b1) exp_q.push_back(bits[n-14 +: 13]);
      for (int j = 0; j <= n; j++) begin
         int hi;
         hi = (j == n) ? 53 : (bits[j] ? (per * 2) / 3 : per / 3);
         @(negedge clk); supply_hi = 1'b1;
         wait_n(40);
         if (chk_reply)
            chk(out_drive == ((j < 13) ? TXW[j] : 1'b1), "R9 reply bit",
                int'(out_drive), int'((j < 13) ? TXW[j] : 1'b1));
         wait_n(hi - 41);
         supply_hi = 1'b0;
         if (j < n) wait_n(per - hi - 1);
      end
      wait_n(450);
   endtask

   // output waveform with the supply echoing it; bad lag on period bad_idx
   task automatic echo(input int count, input int bad_idx);
      for (int p = 0; p < count; p++) begin
         int lag;
         lag = (p == bad_idx) ? 60 : 20;
         @(negedge clk); out_sense = 1'b0;
         wait_n(lag);  supply_hi = 1'b1;
         wait_n(100 - lag); out_sense = 1'b1;
         wait_n(20);   supply_hi = 1'b0;
         wait_n(80);
      end
   endtask

   task automatic end_session();
      @(negedge clk); supply_hi = 1'b1;
      wait_n(2000);
      supply_hi = 1'b0;
      wait_n(100);
   endtask

   initial begin
      tx_word = TXW;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      // R1 reset state
      chk(test_mode == 1'b0, "R1 test_mode", int'(test_mode), 0);
      chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
      chk(out_drive == 1'b1, "R1 out_drive", int'(out_drive), 1);

      // R2 negative: programmed part ignores held-low entry
      blank_dev = 1'b0;
      pulse_por();
      out_sense = 1'b0; wait_n(2000); out_sense = 1'b1; wait_n(20);
      chk(test_mode == 1'b0, "R2 programmed no entry", int'(test_mode), 0);

      // R2 positive: blank part enters
      blank_dev = 1'b1;
      pulse_por();
      out_sense = 1'b0; wait_n(1800); out_sense = 1'b1; wait_n(20);
      chk(test_mode == 1'b1, "R2 blank entry", int'(test_mode), 1);
      blank_dev = 1'b0;
      wait_n(500);

      // R5 R6 command words at several periods
      send_word({6'b0, 1'b1, 4'b1010, 7'h60, 1'b1, 1'b1}, 14, 176, 1'b1, 1'b1);
      send_word({6'b0, 1'b1, 4'b1011, 7'h52, 1'b0, 1'b1}, 14, 150, 1'b1, 1'b1);
      send_word({6'b0, 1'b1, 13'b1011111111111}, 14, 220, 1'b1, 1'b0);
      // R6 surplus bits overwritten
      send_word({4'b0, 1'b1, 13'h0A5C, 2'b01}, 16, 176, 1'b1, 1'b1);
      // R7 short word and bad stop bit
      send_word({10'b0, 10'b1011001110}, 10, 176, 1'b0, 1'b0);
      send_word({6'b0, 1'b0, 13'h1FFF}, 14, 176, 1'b0, 1'b0);
      chk(exp_q.size() == 0, "R6 R8 all words seen", exp_q.size(), 0);

      // R10 session end
      end_session();
      chk(test_mode == 1'b0, "R10 session closed", int'(test_mode), 1'b0);
      send_word({6'b0, 1'b1, 13'h1234}, 14, 176, 1'b0, 1'b0);
      chk(out_drive == 1'b1, "R9 released after session", int'(out_drive), 1);
      chk(exp_q.size() == 0, "R10 no words after exit", exp_q.size(), 0);

      // R3 echo entry
      echo(FOLLOW_N_M1(), -1);
      chk(test_mode == 1'b0, "R3 four periods not enough", int'(test_mode), 0);
      echo(1, -1);
      chk(test_mode == 1'b1, "R3 echo entry", int'(test_mode), 1);
      wait_n(500);
      end_session();
      chk(test_mode == 1'b0, "R10 second exit", int'(test_mode), 0);

      // R4 echo broken by a late follow restarts the count
      echo(6, 2);
      chk(test_mode == 1'b0, "R4 abort restarts count", int'(test_mode), 0);
      echo(1, -1);
      chk(test_mode == 1'b1, "R4 entry after restart", int'(test_mode), 1);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   function automatic int FOLLOW_N_M1();
      return 4;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule